// File: doc/BRIEF.md
# 32-bit ALU with condition flags

This block is the execute-stage arithmetic and logic unit of a small RISC core. Each cycle it may receive one operation: a 4-bit operation code, two 32-bit operands and a 3-bit condition selector. Operand A is the destination register's current value (and the value that is shifted), and operand B is the source value (and the shift count). The result and a write-enable are produced combinationally in the same cycle. The four condition flags are held in a register inside the block and update at the clock edge.

Every operation is predicated. The condition selector is tested against the flags held before the operation. When the test fails, the block neither asserts the write-enable nor changes the flags. Compare and test operations update the flags only. The register file, decode, memory access and forwarding belong to the surrounding core.

Top module: `alu_core`

## Requirements
- R1: After a synchronous active-low reset the flags read 4'b0000, and wr_en is low in every cycle where op_valid is low.
- R2: The flags are packed with Z in bit 0, C in bit 1, N in bit 2 and V in bit 3. For every flag-updating operation, Z is set exactly when the 32-bit result is zero and N equals result bit 31.
- R3: ADD (code 0) gives A+B. C is the carry out of bit 31. V is set when A and B have the same sign and the result's sign differs from it, so 0x7FFFFFFF+1 sets V and 0xFFFFFFFF+1 sets C and Z.
- R4: SUB (code 1) gives A-B. C is the borrow, so 0-1 sets C. V is set when A and B differ in sign and the result's sign differs from A, so 0x80000000-1 sets V.
- R5: CMP (code 2) sets flags as SUB does, and TST (code 6) sets flags as AND does. Neither one asserts wr_en.
- R6: AND (code 3), OR (code 4) and XOR (code 5) write the bitwise result and always clear C and V.
- R7: LSL (code 7) and LSR (code 8) put the last bit shifted out in C and set V when result bit 31 differs from A bit 31. ASR (code 9) fills from the sign bit and never sets V.
- R8: A shift count of 32 or more acts as a count of exactly 32. LSL and LSR then give 0, and ASR gives 32 copies of the sign bit. C is the last bit moved out: A bit 0 for LSL, and A bit 31 for LSR and ASR.
- R9: A shift or rotate count of 0 returns A unchanged and clears C.
- R10: ROL (code 10) rotates A left by B modulo 32. C is the last bit carried around, which is result bit 0, or 0 for a zero rotate. V is cleared.
- R11: MPYU (code 11) returns the 32-bit unsigned product of the low 16 bits of A and B, ignoring their upper halves, for example 0xFFFF*0xFFFF = 0xFFFE0001. C and V are cleared.
- R12: MPYS (code 12) returns the 32-bit product of the low 16 bits of A and B taken as signed values, for example 0x8000*0x8000 = 0x40000000 and 0x8001*0x7FFF = 0xC000FFFF. C and V are cleared.
- R13: The condition selector values are 0 always, 1 Z, 2 not Z, 3 not Z and not N, 4 not N, 5 N, 6 C and 7 V. A condition that fails leaves wr_en low and the flags unchanged.
- R14: Codes 13, 14 and 15 are no-ops: wr_en stays low and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is present this cycle |
| op_code | input | 4 | Operation code |
| cond_sel | input | 3 | Predicate selector |
| opnd_a | input | 32 | Destination value, also the shifted value |
| opnd_b | input | 32 | Source value, also the shift count |
| result | output | 32 | Combinational result |
| wr_en | output | 1 | Write the result to the register file |
| cc_flags | output | 4 | Registered flags {V,N,C,Z} |

## Verification
Predicate evaluation and flag production fall in the same cycle. The condition reads the flags held before the edge, while the operation computes the flags that would replace them at that edge. The bench loads each of four flag states with a compare. It then issues an AND under each of the eight selectors, where a taken AND would always give flags 0000. Each case is judged by wr_en in the issue cycle and by the flags after the edge, which must be either the cleared value or the unchanged prior state, as the bench's own truth table predicts.

// File: rtl/alu_pkg.sv
// Shared types for the ALU: operation codes, predicate codes, flag layout.
// Assumes a 4-bit operation field and a 3-bit predicate field.
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_TST  = 4'd6,
        OP_LSL  = 4'd7,
        OP_LSR  = 4'd8,
        OP_ASR  = 4'd9,
        OP_ROL  = 4'd10,
        OP_MPYU = 4'd11,
        OP_MPYS = 4'd12
    } alu_op_e;

    typedef enum logic [2:0] {
        PR_ALWAYS = 3'd0,
        PR_ZERO   = 3'd1,
        PR_NZERO  = 3'd2,
        PR_GT     = 3'd3,
        PR_GE     = 3'd4,
        PR_LT     = 3'd5,
        PR_CARRY  = 3'd6,
        PR_OVF    = 3'd7
    } pred_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ARITH = 2'd2,
        SH_ROT   = 2'd3
    } shift_e;

    // Bit 0 = Z, bit 1 = C, bit 2 = N, bit 3 = V
    typedef struct packed {
        logic v;
        logic n;
        logic c;
        logic z;
    } cc_t;

endpackage

// File: rtl/alu_pred.sv
// Predicate evaluator: decides whether an operation may commit, from the
// selector and the flags held before the operation. Purely combinational.
module alu_pred
    import alu_pkg::*;
(
    input  logic [2:0] sel,
    input  cc_t        cc,
    output logic       pass
);

    // Map each selector to its flag expression; signed compares use N alone
    always_comb begin
        case (pred_e'(sel))
            PR_ALWAYS: pass = 1'b1;
            PR_ZERO:   pass = cc.z;
            PR_NZERO:  pass = !cc.z;
            PR_GT:     pass = !cc.z && !cc.n;
            PR_GE:     pass = !cc.n;
            PR_LT:     pass = cc.n;
            PR_CARRY:  pass = cc.c;
            default:   pass = cc.v;
        endcase
    end

endmodule

// File: rtl/alu_shifter.sv
// Barrel shifter for left, logical right, arithmetic right and rotate.
// Assumes DATA_W is a power of two. Counts above DATA_W saturate to DATA_W
// for plain shifts; rotates use the count modulo DATA_W.
module alu_shifter
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  shift_e              kind,
    input  logic [DATA_W-1:0]   value,
    input  logic [DATA_W-1:0]   amount,
    output logic [DATA_W-1:0]   res,
    output logic                carry,
    output logic                sign_flip
);

    localparam int CNT_W = $clog2(DATA_W) + 1;
    localparam int ROT_W = CNT_W - 1;
    localparam logic [DATA_W-1:0] FULL = DATA_W'(DATA_W);

    logic [CNT_W-1:0]          amt;
    logic [ROT_W-1:0]          ramt;
    logic [DATA_W:0]           wide_l;
    logic [DATA_W:0]           wide_r;
    logic signed [DATA_W:0]    sext;
    logic [DATA_W:0]           wide_a;
    logic [2*DATA_W-1:0]       wide_rot;

    // Clamp the shift count so that any oversize count acts as a full shift
    always_comb begin
        if (amount > FULL) amt = FULL[CNT_W-1:0];
        else               amt = amount[CNT_W-1:0];
        ramt = amount[ROT_W-1:0];
    end

    // One guard bit on the far side of each shift captures the last bit out
    always_comb begin
        wide_l   = {1'b0, value} << amt;
        wide_r   = {value, 1'b0} >> amt;
        sext     = {value, 1'b0};
        wide_a   = sext >>> amt;
        wide_rot = {value, value} << ramt;
    end

    // Select the variant, its carry and the sign-change indication
    always_comb begin
        case (kind)
            SH_LEFT:  begin res = wide_l[DATA_W-1:0]; carry = wide_l[DATA_W]; end
            SH_RIGHT: begin res = wide_r[DATA_W:1];   carry = wide_r[0];      end
            SH_ARITH: begin res = wide_a[DATA_W:1];   carry = wide_a[0];      end
            default:  begin
                res   = wide_rot[2*DATA_W-1:DATA_W];
                carry = (ramt != '0) && wide_rot[DATA_W];
            end
        endcase
        sign_flip = (kind != SH_ROT) && (res[DATA_W-1] != value[DATA_W-1]);
    end

endmodule

// File: rtl/alu_mult.sv
// Half-width multiplier: multiplies the low halves of two operands and
// returns a full-width product. IS_SIGNED selects two's-complement operands.
module alu_mult #(
    parameter int HALF_W    = 16,
    parameter bit IS_SIGNED = 1'b0
) (
    input  logic [HALF_W-1:0]   x,
    input  logic [HALF_W-1:0]   y,
    output logic [2*HALF_W-1:0] prod
);

    localparam int PROD_W = 2 * HALF_W;

    generate
        if (IS_SIGNED) begin : g_signed
            logic signed [PROD_W-1:0] xs;
            logic signed [PROD_W-1:0] ys;
            logic signed [PROD_W-1:0] ps;
            // Sign-extend both operands, then keep the low full-width product
            always_comb begin
                xs   = {{HALF_W{x[HALF_W-1]}}, x};
                ys   = {{HALF_W{y[HALF_W-1]}}, y};
                ps   = xs * ys;
                prod = ps;
            end
        end else begin : g_unsigned
            // Zero-extend both operands and multiply
            always_comb begin
                prod = {{HALF_W{1'b0}}, x} * {{HALF_W{1'b0}}, y};
            end
        end
    endgenerate

endmodule

// File: rtl/alu_core.sv
// Predicated ALU with a registered flag word. Result and write-enable are
// combinational; flags update at the clock edge when an operation commits.
// Assumes DATA_W is even and a power of two.
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [3:0]        op_code,
    input  logic [2:0]        cond_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic [3:0]        cc_flags
);

    localparam int HALF_W = DATA_W / 2;
    localparam int MSB    = DATA_W - 1;

    alu_op_e           op;
    cc_t               cc_q;
    cc_t               cc_d;
    logic              cond_pass;
    logic [DATA_W:0]   sum;
    logic [DATA_W:0]   diff;
    logic [DATA_W-1:0] sh_res;
    logic              sh_c;
    logic              sh_v;
    logic [DATA_W-1:0] mul_u;
    logic [DATA_W-1:0] mul_s;
    shift_e            sh_kind;
    logic              writes;
    logic              known;
    logic              c_new;
    logic              v_new;

    assign op = alu_op_e'(op_code);

    alu_pred u_pred (
        .sel  (cond_sel),
        .cc   (cc_q),
        .pass (cond_pass)
    );

    alu_shifter #(.DATA_W(DATA_W)) u_shift (
        .kind      (sh_kind),
        .value     (opnd_a),
        .amount    (opnd_b),
        .res       (sh_res),
        .carry     (sh_c),
        .sign_flip (sh_v)
    );

    alu_mult #(.HALF_W(HALF_W), .IS_SIGNED(1'b0)) u_mulu (
        .x    (opnd_a[HALF_W-1:0]),
        .y    (opnd_b[HALF_W-1:0]),
        .prod (mul_u)
    );

    alu_mult #(.HALF_W(HALF_W), .IS_SIGNED(1'b1)) u_muls (
        .x    (opnd_a[HALF_W-1:0]),
        .y    (opnd_b[HALF_W-1:0]),
        .prod (mul_s)
    );

    // Adder and subtractor with a carry/borrow bit above the data width
    always_comb begin
        sum  = {1'b0, opnd_a} + {1'b0, opnd_b};
        diff = {1'b0, opnd_a} - {1'b0, opnd_b};
    end

    // Pick the shifter variant from the operation code
    always_comb begin
        case (op)
            OP_LSR:  sh_kind = SH_RIGHT;
            OP_ASR:  sh_kind = SH_ARITH;
            OP_ROL:  sh_kind = SH_ROT;
            default: sh_kind = SH_LEFT;
        endcase
    end

    // Result mux with per-operation carry, overflow and write policy
    always_comb begin
        result = '0;
        c_new  = 1'b0;
        v_new  = 1'b0;
        writes = 1'b1;
        known  = 1'b1;
        case (op)
            OP_ADD: begin
                result = sum[MSB:0];
                c_new  = sum[DATA_W];
                v_new  = (opnd_a[MSB] == opnd_b[MSB]) && (sum[MSB] != opnd_a[MSB]);
            end
            OP_SUB, OP_CMP: begin
                result = diff[MSB:0];
                c_new  = diff[DATA_W];
                v_new  = (opnd_a[MSB] != opnd_b[MSB]) && (diff[MSB] != opnd_a[MSB]);
                writes = (op == OP_SUB);
            end
            OP_AND, OP_TST: begin
                result = opnd_a & opnd_b;
                writes = (op == OP_AND);
            end
            OP_OR:   result = opnd_a | opnd_b;
            OP_XOR:  result = opnd_a ^ opnd_b;
            OP_LSL, OP_LSR, OP_ASR, OP_ROL: begin
                result = sh_res;
                c_new  = sh_c;
                v_new  = sh_v;
            end
            OP_MPYU: result = mul_u;
            OP_MPYS: result = mul_s;
            default: begin
                writes = 1'b0;
                known  = 1'b0;
            end
        endcase
        cc_d.z = (result == '0);
        cc_d.n = result[MSB];
        cc_d.c = c_new;
        cc_d.v = v_new;
    end

    assign wr_en    = op_valid && cond_pass && writes;
    assign cc_flags = cc_q;

    // Flag register: cleared by reset, loaded only by a committing operation
    always_ff @(posedge clk) begin
        if (!rst_n)                             cc_q <= '0;
        else if (op_valid && cond_pass && known) cc_q <= cc_d;
    end

    // A failed predicate must neither write nor disturb the flags
    a_r13_false_cond_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !cond_pass) |-> !wr_en);
    a_r13_false_cond_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !cond_pass) |=> (cc_flags == $past(cc_flags)));

    // Compare and test never request a register write
    a_r5_compare_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_code == 4'd2 || op_code == 4'd6)) |-> !wr_en);

    // Logical operations leave C and V cleared
    a_r6_logic_clears_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cond_pass && (op_code >= 4'd3 && op_code <= 4'd6))
        |=> (!cc_flags[1] && !cc_flags[3]));

    // Multiplies leave C and V cleared
    a_r11_mult_clears_cv: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cond_pass && (op_code == 4'd11 || op_code == 4'd12))
        |=> (!cc_flags[1] && !cc_flags[3]));

    // Z follows the committed result of every defined operation
    a_r2_z_tracks_result: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cond_pass && op_code <= 4'd12)
        |=> (cc_flags[0] == ($past(result) == '0)));

    // A zero shift or rotate count returns the operand untouched
    a_r9_zero_count_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd7 && op_code <= 4'd10 && opnd_b == '0)
        |-> (result == opnd_a));

    // Arithmetic right shift never changes the sign bit
    a_r7_asr_keeps_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && cond_pass && op_code == 4'd9) |=> !cc_flags[3]);

    // Undefined codes leave the flags alone
    a_r14_undefined_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code > 4'd12) |=> (cc_flags == $past(cc_flags)));

endmodule

// File: tb/sim_alu_core.sv
// Directed bench for alu_core: one task per scenario, each checking itself.
module sim_alu_core;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [2:0]  cond_sel = 3'd0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [31:0] result;
    logic        wr_en;
    logic [3:0]  cc_flags;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    alu_core u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .cond_sel (cond_sel),
        .opnd_a   (opnd_a),
        .opnd_b   (opnd_b),
        .result   (result),
        .wr_en    (wr_en),
        .cc_flags (cc_flags)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // Issue one operation at a falling edge; sample outputs, then flags after the edge
    task automatic issue(input logic [3:0] op, input logic [2:0] c,
                         input logic [31:0] a, input logic [31:0] b,
                         output logic [31:0] r, output logic w, output logic [3:0] f);
        op_valid = 1'b1; op_code = op; cond_sel = c; opnd_a = a; opnd_b = b;
        #2;
        r = result;
        w = wr_en;
        @(posedge clk);
        @(negedge clk);
        f = cc_flags;
        op_valid = 1'b0;
    endtask

    // Run an always-taken writing operation and check result, write and flags
    task automatic expect_op(input string req, input logic [3:0] op,
                             input logic [31:0] a, input logic [31:0] b,
                             input logic [31:0] er, input logic [3:0] ef);
        logic [31:0] r; logic w; logic [3:0] f;
        issue(op, 3'd0, a, b, r, w, f);
        chk({req, " result"}, r, er);
        chk({req, " wr_en"}, {31'd0, w}, 32'd1);
        chk({req, " flags"}, {28'd0, f}, {28'd0, ef});
    endtask

    task automatic t_reset;
        chk("R1 flags after reset", {28'd0, cc_flags}, 32'd0);
        #2;
        chk("R1 idle wr_en", {31'd0, wr_en}, 32'd0);
    endtask

    task automatic t_add;
        expect_op("R3 add overflow", 4'd0, 32'h7FFF_FFFF, 32'd1, 32'h8000_0000, 4'b1100);
        expect_op("R3 add carry", 4'd0, 32'hFFFF_FFFF, 32'd1, 32'h0, 4'b0011);
        expect_op("R2 add plain", 4'd0, 32'd20, 32'd22, 32'd42, 4'b0000);
    endtask

    task automatic t_sub;
        expect_op("R4 sub overflow", 4'd1, 32'h8000_0000, 32'd1, 32'h7FFF_FFFF, 4'b1000);
        expect_op("R4 sub borrow", 4'd1, 32'd0, 32'd1, 32'hFFFF_FFFF, 4'b0110);
    endtask

    task automatic t_compare;
        logic [31:0] r; logic w; logic [3:0] f;
        issue(4'd2, 3'd0, 32'd5, 32'd5, r, w, f);
        chk("R5 cmp no write", {31'd0, w}, 32'd0);
        chk("R5 cmp flags", {28'd0, f}, 32'b0001);
        issue(4'd6, 3'd0, 32'hF000_0000, 32'h8000_0001, r, w, f);
        chk("R5 tst no write", {31'd0, w}, 32'd0);
        chk("R5 tst flags", {28'd0, f}, 32'b0100);
    endtask

    task automatic t_logic;
        logic [31:0] r; logic w; logic [3:0] f;
        issue(4'd2, 3'd0, 32'h8000_0000, 32'd1, r, w, f); // leaves V set
        expect_op("R6 xor clears v", 4'd5, 32'hFFFF_FFFF, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 4'b0100);
        issue(4'd2, 3'd0, 32'd0, 32'd1, r, w, f);         // leaves C set
        expect_op("R6 and clears c", 4'd3, 32'h74, 32'hFF, 32'h74, 4'b0000);
        expect_op("R6 or", 4'd4, 32'h3500, 32'h74, 32'h3574, 4'b0000);
    endtask

    task automatic t_shift;
        expect_op("R7 lsr carry one", 4'd8, 32'd1, 32'd1, 32'd0, 4'b0011);
        expect_op("R7 lsr carry zero", 4'd8, 32'd0, 32'd1, 32'd0, 4'b0001);
        expect_op("R7 lsr sign change", 4'd8, 32'h8000_0000, 32'd1, 32'h4000_0000, 4'b1000);
        expect_op("R7 lsl into sign", 4'd7, 32'h4000_0000, 32'd1, 32'h8000_0000, 4'b1100);
        expect_op("R7 lsl out of sign", 4'd7, 32'h8000_0000, 32'd1, 32'h0, 4'b1011);
        expect_op("R7 lsl by 8", 4'd7, 32'h35, 32'd8, 32'h3500, 4'b0000);
        expect_op("R7 asr by 4", 4'd9, 32'h8000_0000, 32'd4, 32'hF800_0000, 4'b0100);
    endtask

    task automatic t_wide_count;
        expect_op("R8 lsr by 32", 4'd8, 32'hFFFF_FFFF, 32'd32, 32'h0, 4'b1011);
        expect_op("R8 lsr by 40", 4'd8, 32'hFFFF_FFFF, 32'd40, 32'h0, 4'b1011);
        expect_op("R8 asr by 32", 4'd9, 32'hFFFF_FFFF, 32'd32, 32'hFFFF_FFFF, 4'b0110);
        expect_op("R8 lsl by 32", 4'd7, 32'h0000_0001, 32'd32, 32'h0, 4'b0011);
        expect_op("R8 asr huge", 4'd9, 32'h4000_0000, 32'h8000_0000, 32'h0, 4'b0001);
    endtask

    task automatic t_zero_count;
        logic [31:0] r; logic w; logic [3:0] f;
        issue(4'd2, 3'd0, 32'd0, 32'd1, r, w, f);         // leaves C set
        expect_op("R9 lsr by 0", 4'd8, 32'hFFFF_FFFF, 32'd0, 32'hFFFF_FFFF, 4'b0100);
        expect_op("R9 lsl by 0", 4'd7, 32'h1234_5678, 32'd0, 32'h1234_5678, 4'b0000);
        expect_op("R9 rol by 0", 4'd10, 32'd5, 32'd0, 32'd5, 4'b0000);
    endtask

    task automatic t_rotate;
        expect_op("R10 rol 31", 4'd10, 32'd1, 32'd31, 32'h8000_0000, 4'b0100);
        expect_op("R10 rol 4", 4'd10, 32'hF000_0001, 32'd4, 32'h0000_001F, 4'b0010);
        expect_op("R10 rol 36", 4'd10, 32'hF000_0001, 32'd36, 32'h0000_001F, 4'b0010);
    endtask

    task automatic t_mult;
        expect_op("R11 mpyu max", 4'd11, 32'h0000_FFFF, 32'h0000_FFFF, 32'hFFFE_0001, 4'b0100);
        expect_op("R11 mpyu half", 4'd11, 32'd23171, 32'd23171, 32'd536895241, 4'b0000);
        expect_op("R11 mpyu upper ignored", 4'd11, 32'hABCD_0003, 32'h1234_0005, 32'd15, 4'b0000);
        expect_op("R12 mpys min", 4'd12, 32'h0000_8000, 32'h0000_8000, 32'h4000_0000, 4'b0000);
        expect_op("R12 mpys mixed", 4'd12, 32'h0000_8001, 32'h0000_7FFF, 32'hC000_FFFF, 4'b0100);
        expect_op("R12 mpys upper ignored", 4'd12, 32'h7777_FFFF, 32'h0000_0003, 32'hFFFF_FFFD, 4'b0100);
    endtask

    function automatic bit pred_truth(input logic [2:0] c, input logic [3:0] f);
        case (c)
            3'd0: return 1'b1;
            3'd1: return f[0];
            3'd2: return !f[0];
            3'd3: return !f[0] && !f[2];
            3'd4: return !f[2];
            3'd5: return f[2];
            3'd6: return f[1];
            default: return f[3];
        endcase
    endfunction

    // Predicate against flag production in the same cycle, all selectors
    task automatic t_predicate;
        logic [31:0] sa [4];
        logic [31:0] sb [4];
        logic [3:0]  sf [4];
        logic [31:0] r; logic w; logic [3:0] f;
        sa[0] = 32'd5;          sb[0] = 32'd5; sf[0] = 4'b0001;
        sa[1] = 32'd0;          sb[1] = 32'd1; sf[1] = 4'b0110;
        sa[2] = 32'h8000_0000;  sb[2] = 32'd1; sf[2] = 4'b1000;
        sa[3] = 32'd5;          sb[3] = 32'd3; sf[3] = 4'b0000;
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 8; c++) begin
                bit take;
                issue(4'd2, 3'd0, sa[s], sb[s], r, w, f);
                chk("R13 setup flags", {28'd0, f}, {28'd0, sf[s]});
                take = pred_truth(3'(c), sf[s]);
                issue(4'd3, 3'(c), 32'd1, 32'd1, r, w, f);
                chk("R13 predicated write", {31'd0, w}, {31'd0, take});
                chk("R13 predicated flags", {28'd0, f}, take ? 32'd0 : {28'd0, sf[s]});
            end
        end
    endtask

    task automatic t_undefined;
        logic [31:0] r; logic w; logic [3:0] f;
        issue(4'd2, 3'd0, 32'd9, 32'd9, r, w, f);
        for (int k = 13; k < 16; k++) begin
            issue(4'(k), 3'd0, 32'd1, 32'd2, r, w, f);
            chk("R14 undefined no write", {31'd0, w}, 32'd0);
            chk("R14 undefined flags", {28'd0, f}, 32'b0001);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_compare();
        t_logic();
        t_shift();
        t_wide_count();
        t_zero_count();
        t_rotate();
        t_mult();
        t_predicate();
        t_undefined();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule